// File: doc/BRIEF.md
# DV Header Block Inserter

This block sits in the transmit datapath of a digital-video stream. At the start of every DIF sequence it produces a synthesized header DIF block one byte at a time. The first bytes of the block carry identification fields, and the first identification byte holds the current DIF sequence number. Host-programmed words fill the bytes that follow. Every byte after those is 0xFF.

The block counts packets through the `pkt_start` strobe. Every 25 counted packets form one DIF sequence. The sequence number wraps at a limit set by the video system, and each wrap ends a frame. A standard-definition header is 80 bytes. A high-definition header is 160 bytes, and by default it is emitted twice, once for each of the two header locations.

Bytes leave on a valid/ready stream. A byte is transferred on every cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the byte and `out_last` hold steady and generation stalls. `out_valid` never drops before the last byte has been accepted.

Top module: `dv_hdr_inserter`

## Requirements
- R1: In standard mode each header is 80 bytes. Byte 0 is {4'h1, seq[3:0]}, byte 1 is 0x07 and byte 2 is 0x00. Bytes 3..7 are bytes 3..7 of the 64-bit value {word0, word1}, taken most significant byte first. Bytes 8..79 are 0xFF.
- R2: The host writes through `cfg_addr`. Address 0 selects header word0, address 1 selects header word1, and address 2 selects control. The control bits are: bit0 insert enable, bit1 PAL (0 = NTSC), bit2 high-definition, and bit3 single copy. All registers reset to zero. The header words are captured when a header starts.
- R3: A header is emitted only for a `pkt_start` that arrives at packet position 0 of a sequence while insertion is enabled. Otherwise no byte is emitted.
- R4: Packet position advances on each `pkt_start` only while insertion is enabled. After position 24 it returns to 0 and the sequence number increments.
- R5: The sequence number returns to 0 after 9 in NTSC and after 11 in PAL.
- R6: In high-definition mode each header is 160 bytes. Byte 0 is {word0[31:28], seq[3:0]}, bytes 1..7 are bytes 1..7 of {word0, word1}, and bytes 8..159 are 0xFF.
- R7: In high-definition mode the header is emitted twice back to back, once per header location. With the single-copy bit set it is emitted once.
- R8: One byte is transferred per cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, the data and `out_last` hold. `out_last` marks the final byte of the final copy.
- R9: The mode bits are sampled only at a frame start, which is packet position 0 with sequence number 0. Control writes made mid-frame take effect at the next frame.
- R10: The packet position and sequence number keep their values while the source is idle. Only `dp_reset` or `rst_n` clears them, and `dp_reset` leaves the host registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of all state |
| dp_reset | input | 1 | Synchronous datapath reset: clears counters and emission |
| cfg_wr | input | 1 | Host register write strobe |
| cfg_addr | input | 2 | Host register address |
| cfg_wdata | input | 32 | Host write data |
| pkt_start | input | 1 | One-cycle strobe per packet |
| out_valid | output | 1 | Header byte available |
| out_data | output | 8 | Header byte |
| out_last | output | 1 | Final byte of this sequence's header output |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
The assertions assume that `pkt_start` never arrives while a header is still being emitted. The stimulus keeps to this by waiting until the reference queue is empty and `out_valid` is low before it raises the strobe. The host registers are also written only while the output is idle, so a mid-stream write cannot race the start-of-header capture. `out_ready` is driven at random, including long runs held low, and the stall assertions and the byte-by-byte comparison both rely on that random pattern.

// File: rtl/dvh_pkg.sv
package dvh_pkg;
  // Control word, bit0 = insert enable ... bit3 = single copy
  typedef struct packed {
    logic single;
    logic hd;
    logic pal;
    logic ins_en;
  } dvh_mode_t;

  localparam int unsigned CTRL_BITS = 4;
  localparam logic [3:0] ID0_TYPE  = 4'h1;
  localparam logic [7:0] ID1_VALUE = 8'h07;
  localparam logic [7:0] ID2_VALUE = 8'h00;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    ADDR_WORD0 = 2'd0,
    ADDR_WORD1 = 2'd1,
    ADDR_CTRL  = 2'd2
  } dvh_addr_e;
endpackage

// File: rtl/dvh_regs.sv
module dvh_regs
  import dvh_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned N_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [N_WORDS*WORD_W-1:0] hdr_bits,
  output dvh_mode_t         mode_cfg
);
  logic [WORD_W-1:0] word_q [N_WORDS];
  dvh_mode_t         mode_q;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (wr_en && addr == 2'(w)) begin
        word_q[w] <= wdata;
      end
    end
    // word 0 occupies the most significant slice
    assign hdr_bits[(N_WORDS-1-w)*WORD_W +: WORD_W] = word_q[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_en && addr == ADDR_CTRL) begin
      mode_q <= dvh_mode_t'(wdata[CTRL_BITS-1:0]);
    end
  end

  assign mode_cfg = mode_q;

  assert_ctrl_reset_R2: assert property (@(posedge clk)
    $rose(rst_n) |-> (mode_q == '0));
endmodule

// File: rtl/dvh_seq_ctr.sv
module dvh_seq_ctr
  import dvh_pkg::*;
#(
  parameter int unsigned PKTS_PER_SEQ = 25,
  parameter int unsigned NTSC_LAST    = 9,
  parameter int unsigned PAL_LAST     = 11,
  localparam int unsigned PKT_W = $clog2(PKTS_PER_SEQ),
  localparam int unsigned SEQ_W = $clog2(PAL_LAST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_reset,
  input  logic             pkt_start,
  input  dvh_mode_t        mode_cfg,
  output dvh_mode_t        mode_eff,
  output logic [SEQ_W-1:0] seq,
  output logic             hdr_go
);
  logic [PKT_W-1:0] pkt_q;
  logic [SEQ_W-1:0] seq_q;
  dvh_mode_t        act_q;
  logic             frame_start;
  logic [SEQ_W-1:0] seq_lim;
  logic             grp_end;

  assign frame_start = (pkt_q == '0) && (seq_q == '0);
  assign mode_eff    = frame_start ? mode_cfg : act_q;
  assign seq_lim     = mode_eff.pal ? SEQ_W'(PAL_LAST) : SEQ_W'(NTSC_LAST);
  assign grp_end     = (pkt_q == PKT_W'(PKTS_PER_SEQ - 1));
  assign hdr_go      = pkt_start && mode_eff.ins_en && (pkt_q == '0);
  assign seq         = seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_q <= '0;
      seq_q <= '0;
      act_q <= '0;
    end else if (dp_reset) begin
      pkt_q <= '0;
      seq_q <= '0;
      act_q <= '0;
    end else if (pkt_start) begin
      act_q <= mode_eff;
      if (mode_eff.ins_en) begin
        if (grp_end) begin
          pkt_q <= '0;
          seq_q <= (seq_q == seq_lim) ? '0 : seq_q + 1'b1;
        end else begin
          pkt_q <= pkt_q + 1'b1;
        end
      end
    end
  end

  assert_pkt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_q <= PKT_W'(PKTS_PER_SEQ - 1));

  assert_seq_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_q <= (act_q.pal ? SEQ_W'(PAL_LAST) : SEQ_W'(NTSC_LAST)));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q != $past(seq_q)) |->
      ($past(dp_reset) || $past(pkt_start && grp_end)));

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !dp_reset) |=> $stable(act_q));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_start && !dp_reset) |=> ($stable(pkt_q) && $stable(seq_q)));
endmodule

// File: rtl/dvh_byte_gen.sv
module dvh_byte_gen
  import dvh_pkg::*;
#(
  parameter int unsigned STD_LEN    = 80,
  parameter int unsigned HD_LEN     = 160,
  parameter int unsigned ID_BYTES   = 3,
  parameter int unsigned HREG_BYTES = 8,
  parameter int unsigned SEQ_W      = 4,
  localparam int unsigned IDX_W  = $clog2(HD_LEN),
  localparam int unsigned SNAP_W = HREG_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_reset,
  input  logic              start,
  input  dvh_mode_t         mode,
  input  logic [SEQ_W-1:0]  seq,
  input  logic [SNAP_W-1:0] hdr_bits,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last
);
  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic              copy_q;
  logic              hd_q;
  logic              single_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [SNAP_W-1:0] snap_q;
  logic [IDX_W-1:0]  blk_end;
  logic              final_copy;
  logic              xfer;
  logic [7:0]        reg_byte;
  logic [7:0]        id_byte;

  assign blk_end    = hd_q ? IDX_W'(HD_LEN - 1) : IDX_W'(STD_LEN - 1);
  assign final_copy = !hd_q || single_q || copy_q;
  assign xfer       = busy_q && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      copy_q   <= 1'b0;
      hd_q     <= 1'b0;
      single_q <= 1'b0;
      seq_q    <= '0;
      snap_q   <= '0;
    end else if (dp_reset) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      copy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q   <= 1'b1;
        idx_q    <= '0;
        copy_q   <= 1'b0;
        hd_q     <= mode.hd;
        single_q <= mode.single;
        seq_q    <= seq;
        snap_q   <= hdr_bits;
      end
    end else if (xfer) begin
      if (idx_q == blk_end) begin
        idx_q <= '0;
        if (final_copy) begin
          busy_q <= 1'b0;
        end else begin
          copy_q <= 1'b1;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // Byte picked from the captured host words, MSB first
  always_comb begin
    reg_byte = FILL_BYTE;
    for (int j = 0; j < HREG_BYTES; j++) begin
      if (idx_q == IDX_W'(j)) begin
        reg_byte = snap_q[(HREG_BYTES-1-j)*8 +: 8];
      end
    end
  end

  always_comb begin
    unique case (idx_q)
      IDX_W'(0): id_byte = {ID0_TYPE, 4'(seq_q)};
      IDX_W'(1): id_byte = ID1_VALUE;
      default:   id_byte = ID2_VALUE;
    endcase
  end

  always_comb begin
    if (hd_q) begin
      out_data = (idx_q == '0) ? {reg_byte[7:4], 4'(seq_q)} : reg_byte;
    end else if (idx_q < IDX_W'(ID_BYTES)) begin
      out_data = id_byte;
    end else begin
      out_data = reg_byte;
    end
  end

  assign out_valid = busy_q;
  assign out_last  = busy_q && (idx_q == blk_end) && final_copy;

  assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n || dp_reset)
    start |-> !busy_q);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || dp_reset)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= blk_end);

  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n || dp_reset)
    (out_last && out_ready) |=> !out_valid);

  assert_no_second_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_q && busy_q) |-> (hd_q && !single_q));
endmodule

// File: rtl/dv_hdr_inserter.sv
module dv_hdr_inserter
  import dvh_pkg::*;
#(
  parameter int unsigned STD_LEN      = 80,
  parameter int unsigned HD_LEN       = 160,
  parameter int unsigned ID_BYTES     = 3,
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned N_WORDS      = 2,
  parameter int unsigned PKTS_PER_SEQ = 25,
  parameter int unsigned NTSC_LAST    = 9,
  parameter int unsigned PAL_LAST     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_reset,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              pkt_start,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready
);
  localparam int unsigned HREG_BYTES = N_WORDS * WORD_W / 8;
  localparam int unsigned SEQ_W      = $clog2(PAL_LAST + 1);

  logic [N_WORDS*WORD_W-1:0] hdr_bits;
  dvh_mode_t                 mode_cfg;
  dvh_mode_t                 mode_eff;
  logic [SEQ_W-1:0]          seq;
  logic                      hdr_go;

  dvh_regs #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .hdr_bits (hdr_bits),
    .mode_cfg (mode_cfg)
  );

  dvh_seq_ctr #(
    .PKTS_PER_SEQ (PKTS_PER_SEQ),
    .NTSC_LAST    (NTSC_LAST),
    .PAL_LAST     (PAL_LAST)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .dp_reset  (dp_reset),
    .pkt_start (pkt_start),
    .mode_cfg  (mode_cfg),
    .mode_eff  (mode_eff),
    .seq       (seq),
    .hdr_go    (hdr_go)
  );

  dvh_byte_gen #(
    .STD_LEN    (STD_LEN),
    .HD_LEN     (HD_LEN),
    .ID_BYTES   (ID_BYTES),
    .HREG_BYTES (HREG_BYTES),
    .SEQ_W      (SEQ_W)
  ) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .dp_reset  (dp_reset),
    .start     (hdr_go),
    .mode      (mode_eff),
    .seq       (seq),
    .hdr_bits  (hdr_bits),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  assert_first_byte_R3: assert property (@(posedge clk) disable iff (!rst_n || dp_reset)
    (hdr_go && !out_valid) |=> out_valid);
endmodule

// File: tb/dv_hdr_inserter_test.sv
module dv_hdr_inserter_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        dp_reset = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pkt_start = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_ready = 1'b0;

  dv_hdr_inserter uut (
    .clk(clk), .rst_n(rst_n), .dp_reset(dp_reset),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pkt_start(pkt_start), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit mon_on = 0;
  int stall_pct = 25;
  string tag = "R8";

  // reference model state
  int unsigned exp_q[$];
  bit          last_q[$];
  int m_pkt = 0, m_seq = 0;
  bit a_en = 0, a_pal = 0, a_hd = 0, a_single = 0;
  logic [31:0] r_w0 = '0, r_w1 = '0;
  logic [3:0]  r_ctrl = '0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      check(1'b0, "R8", "watchdog cycles", cyc, 150000);
      finish_run();
    end
  end

  // per-cycle comparison and ready generation
  always @(negedge clk) begin
    if (mon_on && !done) begin
      bit rdy;
      check(out_valid == (exp_q.size() > 0), tag, "out_valid", out_valid, exp_q.size() > 0);
      if (out_valid && exp_q.size() > 0) begin
        check(out_data == 8'(exp_q[0]), tag, "out_data", out_data, exp_q[0]);
        check(out_last == last_q[0], "R8", "out_last", out_last, last_q[0]);
      end
      rdy = ($urandom_range(99) >= stall_pct);
      out_ready = rdy;
      if (out_valid && rdy && exp_q.size() > 0) begin
        void'(exp_q.pop_front());
        void'(last_q.pop_front());
      end
    end
  end

  function automatic int unsigned reg_byte(int i);
    logic [63:0] all;
    all = {r_w0, r_w1};
    return int'(all[(7-i)*8 +: 8]);
  endfunction

  task automatic push_hdr();
    int len, copies;
    len = a_hd ? 160 : 80;
    copies = (a_hd && !a_single) ? 2 : 1;
    for (int c = 0; c < copies; c++) begin
      for (int i = 0; i < len; i++) begin
        int unsigned b;
        if (i >= 8) b = 'hFF;
        else if (a_hd) b = (i == 0) ? ((reg_byte(0) & 'hF0) | m_seq) : reg_byte(i);
        else if (i == 0) b = 'h10 | m_seq;
        else if (i == 1) b = 'h07;
        else if (i == 2) b = 'h00;
        else b = reg_byte(i);
        exp_q.push_back(b);
        last_q.push_back((c == copies - 1) && (i == len - 1));
      end
    end
  endtask

  task automatic model_pkt();
    if (m_pkt == 0 && m_seq == 0) begin
      a_en = r_ctrl[0]; a_pal = r_ctrl[1]; a_hd = r_ctrl[2]; a_single = r_ctrl[3];
    end
    if (a_en) begin
      if (m_pkt == 0) push_hdr();
      m_pkt++;
      if (m_pkt == 25) begin
        m_pkt = 0;
        m_seq = (m_seq == (a_pal ? 11 : 9)) ? 0 : m_seq + 1;
      end
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() > 0 || out_valid) @(negedge clk);
  endtask

  task automatic send_pkts(int n);
    for (int k = 0; k < n; k++) begin
      wait_idle();
      pkt_start = 1'b1;
      @(posedge clk);
      #1 pkt_start = 1'b0;
      model_pkt();
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    wait_idle();
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_wr = 1'b0;
    if (a == 2'd0) r_w0 = d;
    else if (a == 2'd1) r_w1 = d;
    else if (a == 2'd2) r_ctrl = d[3:0];
  endtask

  task automatic pulse_dp_reset();
    wait_idle();
    dp_reset = 1'b1;
    @(posedge clk);
    #1 dp_reset = 1'b0;
    m_pkt = 0; m_seq = 0;
    a_en = 0; a_pal = 0; a_hd = 0; a_single = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "reset out_valid", out_valid, 0);
    check(out_last == 1'b0, "R8", "reset out_last", out_last, 0);
    mon_on = 1;
    repeat (4) @(negedge clk);

    // insertion disabled: packets produce nothing
    tag = "R3 disabled";
    send_pkts(30);

    // registers at their reset value: bytes 3..7 are zero
    tag = "R2 reset regs";
    wr_reg(2'd2, 32'h1);
    send_pkts(25);

    // programmed words, NTSC wrap
    tag = "R1 R4 R5 NTSC";
    wr_reg(2'd0, 32'hA1B2C3D4);
    wr_reg(2'd1, 32'h5566E7F8);
    send_pkts(25 * 10);

    // mode write mid-frame waits for the frame start
    tag = "R9 mid-frame";
    wr_reg(2'd2, 32'h3);
    send_pkts(25 * 9);

    tag = "R5 PAL";
    send_pkts(25 * 13);

    // idle mid-frame keeps counters; datapath reset clears them
    tag = "R10 hold";
    send_pkts(10);
    repeat (60) @(negedge clk);
    send_pkts(40);
    wr_reg(2'd0, 32'h9C0F1E2D);
    pulse_dp_reset();
    tag = "R10 dp_reset";
    send_pkts(1);
    check(r_w0 == 32'h9C0F1E2D, "R10", "host word kept", r_w0, 32'h9C0F1E2D);
    send_pkts(24);

    // high definition, two copies
    pulse_dp_reset();
    wr_reg(2'd2, 32'h7);
    wr_reg(2'd1, 32'h13579BDF);
    tag = "R6 R7 HD dual";
    send_pkts(25 * 3);

    // high definition, single copy
    pulse_dp_reset();
    wr_reg(2'd2, 32'hF);
    tag = "R7 HD single";
    send_pkts(25 * 2);

    // heavy back-pressure
    pulse_dp_reset();
    stall_pct = 85;
    wr_reg(2'd2, 32'h1);
    tag = "R8 stall";
    send_pkts(25 * 2);
    wr_reg(2'd2, 32'h7);
    send_pkts(25 * 10);

    wait_idle();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule